// File: doc/BRIEF.md
# Link Active-State Power Controller

This controller moves one serial link between three power states. It acts on idle time alone and needs no software. The states are active (L0), a quick standby (L0s) and a deeper low-power state (L1).

The transmit side watches its own idle time. After a short programmed idle count it asks the lane logic for an electrical-idle ordered set and goes to standby. The receive side tracks standby for its own direction, driven by the electrical-idle and fast-training detection strobes. The two sides move independently. L1 is different: the transmit side must have been idle for a longer programmed count, and receive activity must be absent. L1 is then entered for the link as a whole.

Leaving standby sends a programmed number of fast-training ordered sets. Leaving L1 never uses a fast-training exit. It raises a retrain request and holds it until the physical layer reports that retraining is done. A one-hot state output tells the data path when transmission is allowed again.

Top module: `link_aspm_ctrl`

## Requirements
- R1: After reset, `link_state` is 3'b001 and `send_eios`, `send_fts`, `retrain_req`, `rx_standby` and `rx_eios_err` are all low. `link_state` is one-hot: bit 0 is L0, bit 1 is standby (L0s, including its entry and exit), and bit 2 is L1 (including its entry and retraining).
- R2: `aspm_mode` bit 0 enables standby and bit 1 enables L1. With `aspm_mode` = 2'b00 the controller makes no autonomous transition, however long the transmit side stays idle.
- R3: With standby enabled, `tx_pending` low and the idle count at `l0s_idle_lim` or more, the controller raises `send_eios` and reports standby. `send_eios` stays high until an `os_sent` strobe is seen.
- R4: A `tx_pending` cycle during standby starts the exit. `send_fts` stays high until `fts_num` `os_sent` strobes have been counted (a value of 0 counts as one), and then L0 is reported. `link_state[0]` stays low for the whole exit.
- R5: L1 entry needs L1 enabled, `tx_pending` low, the idle count at `l1_idle_lim` or more, and `rx_active` low. From L0 it goes through one electrical-idle ordered set. From standby it goes straight to L1. L1 wins when both entries qualify.
- R6: In L1, `tx_pending` or `rx_active` raises `retrain_req` and never `send_fts`. `retrain_req` holds until `recov_done`, and then L0 is reported.
- R7: `rx_standby` is set by `rx_eios_det` and cleared by `rx_fts_det` or `recov_done`, whatever the transmit state. A set and a clear in the same cycle leave it set.
- R8: An `rx_eios_det` while `rx_standby` is already high sets `rx_eios_err`, which stays high until reset.
- R9: The idle count returns to zero on every `tx_pending` cycle and counts only in L0 and standby. Idle runs shorter than a threshold therefore never cause an entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| aspm_mode | input | 2 | Bit 0 enables standby, bit 1 enables L1 |
| l0s_idle_lim | input | CW | Idle cycles before standby entry |
| l1_idle_lim | input | CW | Idle cycles before L1 entry |
| fts_num | input | FW | Fast-training sets sent on standby exit |
| tx_pending | input | 1 | Transmit data is waiting |
| rx_active | input | 1 | Receive direction is busy |
| rx_eios_det | input | 1 | Electrical-idle set received (strobe) |
| rx_fts_det | input | 1 | Fast-training set received (strobe) |
| os_sent | input | 1 | The requested ordered set went out (strobe) |
| recov_done | input | 1 | Link retraining finished (strobe) |
| send_eios | output | 1 | Request to send an electrical-idle set |
| send_fts | output | 1 | Request to send fast-training sets |
| retrain_req | output | 1 | Request for link retraining |
| link_state | output | 3 | One-hot transmit-side link state |
| rx_standby | output | 1 | Receive direction is in standby |
| rx_eios_err | output | 1 | Sticky flag for an unexpected electrical-idle set |

## Verification
Two events can fall in the same cycle. A `recov_done` that ends L1 also clears receive standby, so the transmit state and `rx_standby` change on the same edge. The bench arranges this by taking the receiver into standby just before the link reaches L1 and then ending retraining. The scoreboard expects one combined change of {`rx_standby`, `link_state`} and no intermediate value. The second case concerns the two idle thresholds: with both entries enabled, the standby threshold fires first, and the later L1 threshold must move the link from standby straight to L1 with no fast-training burst in between.

// File: rtl/aspm_pkg.sv
package aspm_pkg;
  typedef enum logic [2:0] {
    TX_ACT    = 3'd0,
    TX_ENT_S  = 3'd1,
    TX_L0S    = 3'd2,
    TX_EXIT_S = 3'd3,
    TX_ENT_L1 = 3'd4,
    TX_L1     = 3'd5,
    TX_RETR   = 3'd6
  } tx_st_e;

  localparam int unsigned LS_W = 3;
endpackage

// File: rtl/aspm_idle_timer.sv
module aspm_idle_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          count_en,
  input  logic          tx_pending,
  input  logic [CW-1:0] lim_s,
  input  logic [CW-1:0] lim_l1,
  output logic          hit_s,
  output logic          hit_l1
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (tx_pending || !count_en) cnt_d = '0;
    else if (cnt_q != {CW{1'b1}}) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign hit_s  = !tx_pending && (cnt_q >= lim_s);
  assign hit_l1 = !tx_pending && (cnt_q >= lim_l1);

  // R9: a pending transmit cycle empties the idle count
  p_idle_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pending |=> (cnt_q == '0));
endmodule

// File: rtl/aspm_tx_fsm.sv
module aspm_tx_fsm
  import aspm_pkg::*;
#(
  parameter int unsigned FW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          tx_pending,
  input  logic          rx_active,
  input  logic          hit_s,
  input  logic          hit_l1,
  input  logic          os_sent,
  input  logic          recov_done,
  input  logic [FW-1:0] fts_num,
  output tx_st_e        st_q,
  output logic          send_eios,
  output logic          send_fts,
  output logic          retrain_req
);
  tx_st_e        st_d;
  logic [FW-1:0] fts_q, fts_d;
  logic          fts_done;
  logic          go_l1;

  assign go_l1    = mode[1] && hit_l1 && !rx_active;
  assign fts_done = os_sent && (({1'b0, fts_q} + 1'b1) >= {1'b0, fts_num});

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      TX_ACT: begin
        if (go_l1)                st_d = TX_ENT_L1;
        else if (mode[0] && hit_s) st_d = TX_ENT_S;
      end
      TX_ENT_S:  if (os_sent) st_d = TX_L0S;
      TX_L0S: begin
        if (tx_pending) st_d = TX_EXIT_S;
        else if (go_l1) st_d = TX_L1;
      end
      TX_EXIT_S: if (fts_done) st_d = TX_ACT;
      TX_ENT_L1: if (os_sent) st_d = TX_L1;
      TX_L1:     if (tx_pending || rx_active) st_d = TX_RETR;
      TX_RETR:   if (recov_done) st_d = TX_ACT;
      default:   st_d = TX_ACT;
    endcase
  end

  always_comb begin
    fts_d = fts_q;
    if (st_q != TX_EXIT_S) fts_d = '0;
    else if (os_sent)      fts_d = fts_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= TX_ACT;
      fts_q <= '0;
    end else begin
      st_q  <= st_d;
      fts_q <= fts_d;
    end
  end

  assign send_eios   = (st_q == TX_ENT_S) || (st_q == TX_ENT_L1);
  assign send_fts    = (st_q == TX_EXIT_S);
  assign retrain_req = (st_q == TX_RETR);

  // R2: disabled mode never leaves the active state
  p_disabled_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TX_ACT && mode == 2'b00) |=> (st_q == TX_ACT));
  // R3: the electrical-idle request waits for its sent strobe
  p_eios_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (send_eios && !os_sent) |=> send_eios);
  // R4: a fast-training burst only ever follows standby
  p_fts_from_l0s_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(send_fts) |-> ($past(st_q) == TX_L0S));
  // R5: receive activity blocks L1 entry
  p_l1_rx_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TX_ACT && rx_active) |=> (st_q != TX_ENT_L1));
  // R6: L1 exit goes through retraining, not fast training
  p_l1_exit_retrain_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TX_L1 && tx_pending) |=> (retrain_req && !send_fts));
  p_retrain_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (retrain_req && !recov_done) |=> retrain_req);
endmodule

// File: rtl/aspm_rx_standby.sv
module aspm_rx_standby (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_eios_det,
  input  logic rx_fts_det,
  input  logic recov_done,
  output logic standby_q,
  output logic err_q
);
  logic standby_d, err_d;

  always_comb begin
    standby_d = standby_q;
    if (rx_eios_det)                    standby_d = 1'b1;
    else if (rx_fts_det || recov_done) standby_d = 1'b0;
    err_d = err_q || (rx_eios_det && standby_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      standby_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      standby_q <= standby_d;
      err_q     <= err_d;
    end
  end

  // R7: an incoming electrical-idle set puts the receiver in standby
  p_standby_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_eios_det |=> standby_q);
  // R8: the error flag is sticky
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
endmodule

// File: rtl/link_aspm_ctrl.sv
module link_aspm_ctrl
  import aspm_pkg::*;
#(
  parameter int unsigned CW = 8,
  parameter int unsigned FW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      aspm_mode,
  input  logic [CW-1:0]   l0s_idle_lim,
  input  logic [CW-1:0]   l1_idle_lim,
  input  logic [FW-1:0]   fts_num,
  input  logic            tx_pending,
  input  logic            rx_active,
  input  logic            rx_eios_det,
  input  logic            rx_fts_det,
  input  logic            os_sent,
  input  logic            recov_done,
  output logic            send_eios,
  output logic            send_fts,
  output logic            retrain_req,
  output logic [LS_W-1:0] link_state,
  output logic            rx_standby,
  output logic            rx_eios_err
);
  tx_st_e st;
  logic   hit_s, hit_l1, count_en;

  assign count_en = (st == TX_ACT) || (st == TX_L0S);

  aspm_idle_timer #(.CW(CW)) u_idle (
    .clk(clk), .rst_n(rst_n), .count_en(count_en), .tx_pending(tx_pending),
    .lim_s(l0s_idle_lim), .lim_l1(l1_idle_lim), .hit_s(hit_s), .hit_l1(hit_l1)
  );

  aspm_tx_fsm #(.FW(FW)) u_tx (
    .clk(clk), .rst_n(rst_n), .mode(aspm_mode), .tx_pending(tx_pending),
    .rx_active(rx_active), .hit_s(hit_s), .hit_l1(hit_l1), .os_sent(os_sent),
    .recov_done(recov_done), .fts_num(fts_num), .st_q(st),
    .send_eios(send_eios), .send_fts(send_fts), .retrain_req(retrain_req)
  );

  aspm_rx_standby u_rx (
    .clk(clk), .rst_n(rst_n), .rx_eios_det(rx_eios_det), .rx_fts_det(rx_fts_det),
    .recov_done(recov_done), .standby_q(rx_standby), .err_q(rx_eios_err)
  );

  always_comb begin
    unique case (st)
      TX_ENT_S, TX_L0S, TX_EXIT_S: link_state = 3'b010;
      TX_ENT_L1, TX_L1, TX_RETR:   link_state = 3'b100;
      default:                     link_state = 3'b001;
    endcase
  end

  // R1: the state output is always one-hot
  p_state_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(link_state) == 1);
endmodule

// File: tb/link_aspm_ctrl_tb.sv
module link_aspm_ctrl_tb;
  localparam int unsigned CW = 8;
  localparam int unsigned FW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    aspm_mode = 2'b00;
  logic [CW-1:0] l0s_idle_lim = 8'd4;
  logic [CW-1:0] l1_idle_lim = 8'd12;
  logic [FW-1:0] fts_num = 4'd3;
  logic          tx_pending = 1'b1;
  logic          rx_active = 1'b0;
  logic          rx_eios_det = 1'b0;
  logic          rx_fts_det = 1'b0;
  logic          os_sent = 1'b0;
  logic          recov_done = 1'b0;
  logic          send_eios, send_fts, retrain_req, rx_standby, rx_eios_err;
  logic [2:0]    link_state;

  int checks = 0;
  int fails = 0;
  int fts_pulses = 0;
  bit mon_on = 1'b0;
  logic [3:0] exp_q[$];
  logic [3:0] prev_obs;

  always #2 clk = ~clk;

  link_aspm_ctrl #(.CW(CW), .FW(FW)) u_dut (
    .clk(clk), .rst_n(rst_n), .aspm_mode(aspm_mode), .l0s_idle_lim(l0s_idle_lim),
    .l1_idle_lim(l1_idle_lim), .fts_num(fts_num), .tx_pending(tx_pending),
    .rx_active(rx_active), .rx_eios_det(rx_eios_det), .rx_fts_det(rx_fts_det),
    .os_sent(os_sent), .recov_done(recov_done), .send_eios(send_eios),
    .send_fts(send_fts), .retrain_req(retrain_req), .link_state(link_state),
    .rx_standby(rx_standby), .rx_eios_err(rx_eios_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [3:0] e);
    exp_q.push_back(e);
  endtask

  // ordered-set responder: one sent strobe every other cycle while requested
  initial forever begin
    @(negedge clk);
    os_sent = (send_eios || send_fts) && !os_sent;
    if (os_sent && send_fts) fts_pulses++;
  end

  // scoreboard monitor on {rx_standby, link_state}
  initial forever begin
    @(negedge clk);
    if (mon_on && ({rx_standby, link_state} != prev_obs)) begin
      if (exp_q.size() == 0)
        check(1'b0, "SEQ unexpected change", {rx_standby, link_state}, prev_obs);
      else begin
        logic [3:0] e;
        e = exp_q.pop_front();
        check({rx_standby, link_state} == e, "SEQ", {rx_standby, link_state}, e);
      end
      prev_obs = {rx_standby, link_state};
    end
  end

  task automatic wait_settled(input logic [2:0] ls, input int tmo);
    for (int i = 0; i < tmo; i++) begin
      @(negedge clk);
      if (link_state == ls && !send_eios && !send_fts && !retrain_req) return;
    end
    check(1'b0, "timeout waiting for state", link_state, ls);
  endtask

  task automatic finish_run();
    check(exp_q.size() == 0, "SEQ leftover expectations", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(link_state == 3'b001, "R1 link_state", link_state, 1);
    check({send_eios, send_fts, retrain_req, rx_standby, rx_eios_err} == 5'b0,
          "R1 requests idle", {send_eios, send_fts, retrain_req, rx_standby, rx_eios_err}, 0);
    prev_obs = {rx_standby, link_state};
    mon_on = 1'b1;

    // R2 disabled: long idle, no change
    aspm_mode = 2'b00;
    tx_pending = 1'b0;
    repeat (60) @(negedge clk);
    check(link_state == 3'b001, "R2 disabled stays L0", link_state, 1);

    // R9 short idle runs never reach the standby threshold
    aspm_mode = 2'b01;
    for (int k = 0; k < 15; k++) begin
      tx_pending = 1'b1; @(negedge clk);
      tx_pending = 1'b0; repeat (3) @(negedge clk);
    end
    tx_pending = 1'b1;
    @(negedge clk);
    check(link_state == 3'b001, "R9 short idle no entry", link_state, 1);

    // R3 standby entry, R4 exit with three fast-training sets
    push(4'b0010); push(4'b0001);
    tx_pending = 1'b0;
    for (int i = 0; i < 50 && !send_eios; i++) @(negedge clk);
    check(send_eios && link_state == 3'b010, "R3 eios with standby", {send_eios, link_state}, 4'b1010);
    wait_settled(3'b010, 50);
    fts_pulses = 0;
    tx_pending = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(send_fts && !link_state[0], "R4 data blocked during exit", {send_fts, link_state}, 4'b1010);
    wait_settled(3'b001, 50);
    check(fts_pulses == 3, "R4 fts count", fts_pulses, 3);

    // R4 zero count behaves as one
    fts_num = 4'd0;
    push(4'b0010); push(4'b0001);
    tx_pending = 1'b0;
    repeat (10) @(negedge clk);
    wait_settled(3'b010, 50);
    fts_pulses = 0;
    tx_pending = 1'b1;
    repeat (2) @(negedge clk);
    wait_settled(3'b001, 50);
    check(fts_pulses == 1, "R4 zero count sends one", fts_pulses, 1);
    fts_num = 4'd3;

    // R5 L1 only: receive activity blocks entry
    aspm_mode = 2'b10;
    rx_active = 1'b1;
    tx_pending = 1'b0;
    repeat (40) @(negedge clk);
    check(link_state == 3'b001, "R5 rx activity blocks L1", link_state, 1);
    push(4'b0100);
    rx_active = 1'b0;
    wait_settled(3'b100, 50);
    // R6 exit via retraining
    push(4'b0001);
    tx_pending = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(retrain_req && !send_fts, "R6 retrain not fts", {retrain_req, send_fts}, 2'b10);
    repeat (5) @(negedge clk);
    check(retrain_req && link_state == 3'b100, "R6 retrain held", {retrain_req, link_state}, 4'b1100);
    recov_done = 1'b1; @(negedge clk); recov_done = 1'b0;
    wait_settled(3'b001, 10);

    // R7 / R8 receive standby and error flag (transmit side held busy)
    aspm_mode = 2'b00;
    push(4'b1001);
    rx_eios_det = 1'b1; @(negedge clk); rx_eios_det = 1'b0;
    @(negedge clk);
    check(rx_standby && !rx_eios_err, "R7 standby set, no error", {rx_standby, rx_eios_err}, 2'b10);
    rx_eios_det = 1'b1; @(negedge clk); rx_eios_det = 1'b0;
    @(negedge clk);
    check(rx_eios_err, "R8 error on repeated eios", rx_eios_err, 1);
    push(4'b0001);
    rx_fts_det = 1'b1; @(negedge clk); rx_fts_det = 1'b0;
    @(negedge clk);
    check(!rx_standby && rx_eios_err, "R7/R8 cleared by fts, error sticky", {rx_standby, rx_eios_err}, 2'b01);

    // R5 both enabled: standby first, then straight to L1; R6/R7 combined exit
    aspm_mode = 2'b11;
    push(4'b1001); push(4'b1010); push(4'b1100); push(4'b0001);
    rx_eios_det = 1'b1; @(negedge clk); rx_eios_det = 1'b0;
    tx_pending = 1'b0;
    fts_pulses = 0;
    wait_settled(3'b100, 80);
    check(fts_pulses == 0, "R5 standby to L1 without fts", fts_pulses, 0);
    rx_active = 1'b1;
    @(negedge clk); @(negedge clk);
    check(retrain_req && !send_fts, "R6 rx wakes L1 via retrain", {retrain_req, send_fts}, 2'b10);
    rx_active = 1'b0;
    tx_pending = 1'b1;
    recov_done = 1'b1; @(negedge clk); recov_done = 1'b0;
    @(negedge clk);
    check({rx_standby, link_state} == 4'b0001, "R7 recov clears rx with L0", {rx_standby, link_state}, 1);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule